// File: doc/BRIEF.md
# Bus Region Access Protection Checker

This block decides, within the address phase of a bus transfer, whether the transfer may go ahead. It compares the transfer address against a small array of region descriptors. Each descriptor has an inclusive start and end address, a valid bit, and a permission set for each bus master. A master has a 2-bit supervisor code and a 3-bit user field in every region. A region that covers the address and permits the access grants the transfer. The transfer is allowed when at least one region grants it. In every other case it is an access error, and the surrounding bus logic must not perform it.

The allow/error decision is purely combinational in the same cycle. The first error is also recorded in sticky registers by a two-state capture machine. In state `CAP_EMPTY` the machine waits. An error takes it to `CAP_HELD` (transition *capture*) and loads the address, master ID, privilege and access type. It stays in `CAP_HELD` and ignores further errors (transition *hold*) until an `err_clr` pulse arrives. On that pulse it either returns to `CAP_EMPTY` (transition *release*), or, if a new error arrives in the same cycle, stays in `CAP_HELD` with the new values loaded (transition *recapture*).

Access type encoding on `acc_type` and `err_type`: 00 read, 01 write, 10 instruction fetch, 11 reserved.

Top module: `region_guard`

## Requirements
- R1: Region i hits only when `rgn_valid[i]` is 1 and start <= address <= end, with both bounds inclusive. The hit is shown on `rgn_hit[i]` while `acc_valid` is 1. A region whose end is below its start never hits.
- R2: In user mode the region's 3-bit user field for the master applies: bit 2 permits read, bit 1 permits write, bit 0 permits fetch.
- R3: In supervisor mode, code 00 permits read, write and fetch. Code 01 permits read and fetch but not write. Code 10 permits read and write but not fetch.
- R4: Supervisor code 11 grants exactly what the same master's user field in that region grants.
- R5: Master m uses bits [2m+1:2m] of a region's supervisor vector and bits [3m+2:3m] of its user vector. The region's slice is at offset i*NM*2 (supervisor) or i*NM*3 (user). One master's settings never affect another master.
- R6: `acc_allow` is 1 when at least one hitting region permits the access, even if other hitting regions deny it. `acc_error` is then 0.
- R7: A valid access with no hitting region that permits it, including one that hits no region, gives `acc_error`=1 and `acc_allow`=0. Access type 11 is never permitted.
- R8: While `acc_valid` is 0, both `acc_allow` and `acc_error` are 0 and nothing is captured.
- R9: In `CAP_EMPTY`, an error sets `err_flag` at the next clock edge. At the same edge it loads `err_addr`, `err_master`, `err_super` and `err_type` from the erroring access.
- R10: In `CAP_HELD` without `err_clr`, new errors leave the flag and all captured fields unchanged.
- R11: An `err_clr` pulse in `CAP_HELD` clears `err_flag` at the next edge. If an error occurs in that same cycle, the flag stays set and the new access's fields are loaded instead.
- R12: After reset the state is `CAP_EMPTY`, and `err_flag` and all captured fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An address phase is present |
| acc_addr | input | AW | Transfer address |
| acc_master | input | MIDW | Bus master ID |
| acc_super | input | 1 | 1 = supervisor, 0 = user |
| acc_type | input | 2 | 00 read, 01 write, 10 fetch, 11 reserved |
| rgn_valid | input | NR | Per-region valid bits |
| rgn_start | input | NR*AW | Region start addresses, region i at [i*AW +: AW] |
| rgn_end | input | NR*AW | Region end addresses (inclusive) |
| rgn_sup_perm | input | NR*NM*2 | Supervisor codes, region i master m at [(i*NM+m)*2 +: 2] |
| rgn_usr_perm | input | NR*NM*3 | User fields, region i master m at [(i*NM+m)*3 +: 3] |
| err_clr | input | 1 | Write-one-to-clear pulse for the error flag |
| acc_allow | output | 1 | Transfer permitted |
| acc_error | output | 1 | Transfer is an access error |
| rgn_hit | output | NR | Per-region hit indications |
| err_flag | output | 1 | Sticky error captured |
| err_addr | output | AW | Captured address |
| err_master | output | MIDW | Captured master ID |
| err_super | output | 1 | Captured privilege |
| err_type | output | 2 | Captured access type |

## Verification
The hardest case to reach is overlap with mixed verdicts: two or more valid regions cover the same address, and only some of them permit the access. A second hard case is an address exactly one step outside a bound. The bench uses a deterministic pseudo-random generator to build many descriptor sets whose regions often overlap. It probes every region at start-1, start, end and end+1, and it crosses each probe with every master, privilege and access type. A directed overlap pair and an exhaustive sweep of supervisor codes against user fields close the remaining gaps. The same-cycle clear-and-error recapture is driven directly.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_FETCH = 2'b10,
        KIND_RSVD  = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rwx_t;

    typedef enum logic {
        CAP_EMPTY = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_e;

    // Supervisor code expansion; code 3 falls through to the user field.
    function automatic rwx_t sup_expand(input logic [1:0] code, input rwx_t usr);
        rwx_t r;
        unique case (code)
            2'b00:   r = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
            2'b01:   r = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
            2'b10:   r = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
            default: r = usr;
        endcase
        return r;
    endfunction

    function automatic logic kind_permitted(input acc_kind_e k, input rwx_t p);
        logic ok;
        unique case (k)
            KIND_READ:  ok = p.rd;
            KIND_WRITE: ok = p.wr;
            KIND_FETCH: ok = p.ex;
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/rg_region_eval.sv
module rg_region_eval
    import region_guard_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NM   = 2,
    parameter int MIDW = 1
) (
    input  logic [AW-1:0]   addr_i,
    input  logic [MIDW-1:0] master_i,
    input  logic            super_i,
    input  acc_kind_e       kind_i,
    input  logic            valid_i,
    input  logic [AW-1:0]   start_i,
    input  logic [AW-1:0]   end_i,
    input  logic [NM*2-1:0] sup_perm_i,
    input  logic [NM*3-1:0] usr_perm_i,
    output logic            hit_o,
    output logic            grant_o,
    output logic            violate_o
);

    logic       in_range;
    logic       master_known;
    logic [1:0] sup_code;
    rwx_t       usr_rwx;
    rwx_t       eff_rwx;
    logic       perm_ok;

    assign in_range = (addr_i >= start_i) && (addr_i <= end_i);
    assign hit_o    = valid_i && in_range;

    // Pick this master's fields out of the region's packed vectors.
    always_comb begin
        master_known = 1'b0;
        sup_code     = 2'b00;
        usr_rwx      = '0;
        for (int m = 0; m < NM; m++) begin
            if (master_i == MIDW'(m)) begin
                master_known = 1'b1;
                sup_code     = sup_perm_i[m*2 +: 2];
                usr_rwx      = rwx_t'(usr_perm_i[m*3 +: 3]);
            end
        end
    end

    always_comb begin
        if (super_i) begin
            eff_rwx = sup_expand(sup_code, usr_rwx);
        end else begin
            eff_rwx = usr_rwx;
        end
        perm_ok = master_known && kind_permitted(kind_i, eff_rwx);
    end

    assign grant_o   = hit_o && perm_ok;
    assign violate_o = hit_o && !perm_ok;

endmodule

// File: rtl/rg_combine.sv
module rg_combine #(
    parameter int NR = 4
) (
    input  logic          acc_valid_i,
    input  logic [NR-1:0] hit_i,
    input  logic [NR-1:0] grant_i,
    input  logic [NR-1:0] violate_i,
    output logic [NR-1:0] hit_o,
    output logic          allow_o,
    output logic          error_o
);

    logic any_grant;
    logic any_violate;
    logic any_hit;

    assign any_grant   = |grant_i;
    assign any_violate = |violate_i;
    assign any_hit     = |hit_i;

    always_comb begin
        hit_o   = acc_valid_i ? hit_i : '0;
        allow_o = 1'b0;
        error_o = 1'b0;
        if (acc_valid_i) begin
            if (any_grant) begin
                // A grant anywhere overrides violations elsewhere.
                allow_o = 1'b1;
            end else if (any_violate || !any_hit) begin
                error_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rg_err_capture.sv
module rg_err_capture
    import region_guard_pkg::*;
#(
    parameter int AW   = 16,
    parameter int MIDW = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            error_i,
    input  logic            clr_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [MIDW-1:0] master_i,
    input  logic            super_i,
    input  logic [1:0]      type_i,
    output logic            flag_o,
    output logic [AW-1:0]   addr_o,
    output logic [MIDW-1:0] master_o,
    output logic            super_o,
    output logic [1:0]      type_o
);

    cap_state_e state_q;
    cap_state_e state_d;
    logic       load;

    // Next-state and load decision.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            CAP_EMPTY: begin
                if (error_i) begin
                    state_d = CAP_HELD;   // capture
                    load    = 1'b1;
                end
            end
            CAP_HELD: begin
                if (clr_i && error_i) begin
                    state_d = CAP_HELD;   // recapture
                    load    = 1'b1;
                end else if (clr_i) begin
                    state_d = CAP_EMPTY;  // release
                end
            end
            default: state_d = CAP_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o   <= '0;
            master_o <= '0;
            super_o  <= 1'b0;
            type_o   <= 2'b00;
        end else if (load) begin
            addr_o   <= addr_i;
            master_o <= master_i;
            super_o  <= super_i;
            type_o   <= type_i;
        end
    end

    always_comb begin
        unique case (state_q)
            CAP_HELD: flag_o = 1'b1;
            default:  flag_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import region_guard_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NR   = 4,
    parameter int NM   = 2,
    parameter int MIDW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [AW-1:0]      acc_addr,
    input  logic [MIDW-1:0]    acc_master,
    input  logic               acc_super,
    input  logic [1:0]         acc_type,
    input  logic [NR-1:0]      rgn_valid,
    input  logic [NR*AW-1:0]   rgn_start,
    input  logic [NR*AW-1:0]   rgn_end,
    input  logic [NR*NM*2-1:0] rgn_sup_perm,
    input  logic [NR*NM*3-1:0] rgn_usr_perm,
    input  logic               err_clr,
    output logic               acc_allow,
    output logic               acc_error,
    output logic [NR-1:0]      rgn_hit,
    output logic               err_flag,
    output logic [AW-1:0]      err_addr,
    output logic [MIDW-1:0]    err_master,
    output logic               err_super,
    output logic [1:0]         err_type
);

    localparam int SUPW = NM * 2;
    localparam int USRW = NM * 3;

    acc_kind_e     kind;
    logic [NR-1:0] hit_raw;
    logic [NR-1:0] grant;
    logic [NR-1:0] violate;

    assign kind = acc_kind_e'(acc_type);

    for (genvar i = 0; i < NR; i++) begin : g_region
        rg_region_eval #(
            .AW  (AW),
            .NM  (NM),
            .MIDW(MIDW)
        ) u_eval (
            .addr_i    (acc_addr),
            .master_i  (acc_master),
            .super_i   (acc_super),
            .kind_i    (kind),
            .valid_i   (rgn_valid[i]),
            .start_i   (rgn_start[i*AW +: AW]),
            .end_i     (rgn_end[i*AW +: AW]),
            .sup_perm_i(rgn_sup_perm[i*SUPW +: SUPW]),
            .usr_perm_i(rgn_usr_perm[i*USRW +: USRW]),
            .hit_o     (hit_raw[i]),
            .grant_o   (grant[i]),
            .violate_o (violate[i])
        );
    end

    rg_combine #(
        .NR(NR)
    ) u_combine (
        .acc_valid_i(acc_valid),
        .hit_i      (hit_raw),
        .grant_i    (grant),
        .violate_i  (violate),
        .hit_o      (rgn_hit),
        .allow_o    (acc_allow),
        .error_o    (acc_error)
    );

    rg_err_capture #(
        .AW  (AW),
        .MIDW(MIDW)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .error_i (acc_error),
        .clr_i   (err_clr),
        .addr_i  (acc_addr),
        .master_i(acc_master),
        .super_i (acc_super),
        .type_i  (acc_type),
        .flag_o  (err_flag),
        .addr_o  (err_addr),
        .master_o(err_master),
        .super_o (err_super),
        .type_o  (err_type)
    );

endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
    parameter int AW   = 16,
    parameter int NR   = 4,
    parameter int MIDW = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic [AW-1:0]   acc_addr,
    input logic [MIDW-1:0] acc_master,
    input logic [NR-1:0]   rgn_valid,
    input logic            err_clr,
    input logic            acc_allow,
    input logic            acc_error,
    input logic [NR-1:0]   rgn_hit,
    input logic            err_flag,
    input logic [AW-1:0]   err_addr,
    input logic [MIDW-1:0] err_master
);

    assert_invalid_never_hits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((rgn_hit & ~rgn_valid) == '0));

    assert_allow_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_allow |-> (rgn_hit != '0));

    assert_miss_is_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && rgn_hit == '0) |-> acc_error);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!acc_allow && !acc_error));

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_error && !err_flag) |=>
            (err_flag && err_addr == $past(acc_addr) && err_master == $past(acc_master)));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> (err_flag && $stable(err_addr) && $stable(err_master)));

    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && err_clr && !acc_error) |=> !err_flag);

endmodule

bind region_guard rg_checker #(
    .AW  (AW),
    .NR  (NR),
    .MIDW(MIDW)
) u_rg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_master(acc_master),
    .rgn_valid (rgn_valid),
    .err_clr   (err_clr),
    .acc_allow (acc_allow),
    .acc_error (acc_error),
    .rgn_hit   (rgn_hit),
    .err_flag  (err_flag),
    .err_addr  (err_addr),
    .err_master(err_master)
);

// File: tb/region_guard_tb.sv
`timescale 1ns/1ps
module region_guard_tb;

    localparam int AW   = 16;
    localparam int NR   = 4;
    localparam int NM   = 2;
    localparam int MIDW = 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               acc_valid = 1'b0;
    logic [AW-1:0]      acc_addr = '0;
    logic [MIDW-1:0]    acc_master = '0;
    logic               acc_super = 1'b0;
    logic [1:0]         acc_type = 2'b00;
    logic [NR-1:0]      rgn_valid = '0;
    logic [NR*AW-1:0]   rgn_start = '0;
    logic [NR*AW-1:0]   rgn_end = '0;
    logic [NR*NM*2-1:0] rgn_sup_perm = '0;
    logic [NR*NM*3-1:0] rgn_usr_perm = '0;
    logic               err_clr = 1'b0;
    logic               acc_allow;
    logic               acc_error;
    logic [NR-1:0]      rgn_hit;
    logic               err_flag;
    logic [AW-1:0]      err_addr;
    logic [MIDW-1:0]    err_master;
    logic               err_super;
    logic [1:0]         err_type;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    region_guard #(.AW(AW), .NR(NR), .NM(NM)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_master(acc_master), .acc_super(acc_super), .acc_type(acc_type),
        .rgn_valid(rgn_valid), .rgn_start(rgn_start), .rgn_end(rgn_end),
        .rgn_sup_perm(rgn_sup_perm), .rgn_usr_perm(rgn_usr_perm), .err_clr(err_clr),
        .acc_allow(acc_allow), .acc_error(acc_error), .rgn_hit(rgn_hit),
        .err_flag(err_flag), .err_addr(err_addr), .err_master(err_master),
        .err_super(err_super), .err_type(err_type)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Arithmetic reference: permission bit for one region/master/mode/type.
    function automatic logic ref_perm(input int i, input int m, input logic sup, input int t);
        int code;
        int u;
        int rwx;
        code = int'(rgn_sup_perm[(i*NM+m)*2 +: 2]);
        u    = int'(rgn_usr_perm[(i*NM+m)*3 +: 3]);
        if (!sup)          rwx = u;
        else if (code == 0) rwx = 7;
        else if (code == 1) rwx = 5;   // read + fetch
        else if (code == 2) rwx = 6;   // read + write
        else               rwx = u;
        if (t == 3) return 1'b0;
        return ((rwx >> (2 - t)) & 1) == 1;
    endfunction

    function automatic logic [NR-1:0] ref_hits(input int a);
        logic [NR-1:0] h = '0;
        for (int i = 0; i < NR; i++) begin
            h[i] = rgn_valid[i] && a >= int'(rgn_start[i*AW +: AW])
                                && a <= int'(rgn_end[i*AW +: AW]);
        end
        return h;
    endfunction

    function automatic logic ref_allow(input int a, input int m, input logic sup, input int t);
        logic [NR-1:0] h = ref_hits(a);
        logic ok = 1'b0;
        for (int i = 0; i < NR; i++) if (h[i] && ref_perm(i, m, sup, t)) ok = 1'b1;
        return ok;
    endfunction

    task automatic probe(input string req, input int a, input int m, input logic sup, input int t);
        logic exp_a;
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_addr   = AW'(a);
        acc_master = MIDW'(m);
        acc_super  = sup;
        acc_type   = 2'(t);
        #1;
        exp_a = ref_allow(a, m, sup, t);
        check(req, {31'd0, acc_allow}, {31'd0, exp_a});
        check(req, {31'd0, acc_error}, {31'd0, !exp_a});
        check(req, {28'd0, rgn_hit}, {28'd0, ref_hits(a)});
    endtask

    task automatic set_region(input int i, input int s, input int e, input logic v);
        rgn_start[i*AW +: AW] = AW'(s);
        rgn_end[i*AW +: AW]   = AW'(e);
        rgn_valid[i]          = v;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        acc_valid = 1'b0;
        err_clr   = 1'b1;
        @(negedge clk);
        err_clr   = 1'b0;
    endtask

    initial begin
        #750000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset values
        check("R12 flag", {31'd0, err_flag}, 32'd0);
        check("R12 addr", {16'd0, err_addr}, 32'd0);
        check("R12 attrs", {28'd0, err_master, err_super, err_type}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 flag after release", {31'd0, err_flag}, 32'd0);

        // R8: idle bus with a missing address -> no decision, no capture
        acc_valid = 1'b0;
        acc_addr  = 16'h4321;
        #1;
        check("R8 allow", {31'd0, acc_allow}, 32'd0);
        check("R8 error", {31'd0, acc_error}, 32'd0);
        @(negedge clk);
        check("R8 no capture", {31'd0, err_flag}, 32'd0);

        // R2 R3 R4 R5: one covering region, every code x field x type x mode
        set_region(0, 0, 16'hFFFF, 1'b1);
        for (int m = 0; m < NM; m++)
            for (int sc = 0; sc < 4; sc++)
                for (int uc = 0; uc < 8; uc++) begin
                    rgn_sup_perm = '0;
                    rgn_usr_perm = '0;
                    rgn_sup_perm[m*2 +: 2] = 2'(sc);
                    rgn_usr_perm[m*3 +: 3] = 3'(uc);
                    for (int s = 0; s < 2; s++)
                        for (int t = 0; t < 4; t++) begin
                            probe("R2 R3 R4 R5 perm sweep", 16'h0800, m, s[0], t);
                            // other master sees its zero fields: R5
                            probe("R5 master isolation", 16'h0800, 1 - m, s[0], t);
                        end
                end

        // R6: overlap with mixed verdicts
        rgn_sup_perm = '0;
        rgn_usr_perm = '0;
        set_region(0, 16'h0100, 16'h01FF, 1'b1);
        set_region(1, 16'h0180, 16'h02FF, 1'b1);
        set_region(2, 0, 0, 1'b0);
        set_region(3, 0, 0, 1'b0);
        rgn_usr_perm[(1*NM+0)*3 +: 3] = 3'b111;
        probe("R6 overlap grant wins", 16'h0180, 0, 1'b0, 0);
        check("R6 both hit", {28'd0, rgn_hit}, 32'h3);
        check("R6 allow", {31'd0, acc_allow}, 32'd1);
        probe("R6 deny only region", 16'h0150, 0, 1'b0, 0);
        check("R6 deny error", {31'd0, acc_error}, 32'd1);
        probe("R7 no hit", 16'h0300, 0, 1'b0, 0);
        check("R7 no hit error", {31'd0, acc_error}, 32'd1);
        probe("R7 reserved type", 16'h0200, 0, 1'b0, 3);
        check("R7 reserved error", {31'd0, acc_error}, 32'd1);

        // R1 R6 R7: pseudo-random overlapping descriptor sets, boundary probes
        for (int p = 0; p < 30; p++) begin
            for (int i = 0; i < NR; i++) begin
                int s;
                int e;
                s = int'(next_rand() >> 16) & 16'hFFF0;
                s = s & 16'h3FFF;
                e = s + (int'(next_rand() >> 20) & 16'h0FFF);
                if ((next_rand() & 32'h7) == 0) e = s - 1;
                if (e > 16'hFFFF) e = 16'hFFFF;
                if (e < 0) e = 16'hFFFF;
                set_region(i, s, e, (next_rand() & 32'h3) != 0);
            end
            rgn_sup_perm = 16'(next_rand());
            rgn_usr_perm = 24'(next_rand());
            for (int i = 0; i < NR; i++) begin
                int b[4];
                b[0] = (int'(rgn_start[i*AW +: AW]) - 1) & 16'hFFFF;
                b[1] = int'(rgn_start[i*AW +: AW]);
                b[2] = int'(rgn_end[i*AW +: AW]);
                b[3] = (int'(rgn_end[i*AW +: AW]) + 1) & 16'hFFFF;
                for (int k = 0; k < 4; k++)
                    for (int m = 0; m < NM; m++)
                        for (int s = 0; s < 2; s++)
                            for (int t = 0; t < 4; t++)
                                probe("R1 R6 R7 random bounds", b[k], m, s[0], t);
            end
        end

        // R9 R10 R11: capture machine
        clear_flag();
        check("R11 cleared before capture", {31'd0, err_flag}, 32'd0);
        rgn_valid = '0;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 16'hA5A5; acc_master = 1'b1;
        acc_super = 1'b1; acc_type = 2'b01;
        @(negedge clk);
        check("R9 flag", {31'd0, err_flag}, 32'd1);
        check("R9 addr", {16'd0, err_addr}, 32'hA5A5);
        check("R9 attrs", {28'd0, err_master, err_super, err_type}, 32'b1101);
        acc_addr = 16'h1111; acc_master = 1'b0; acc_super = 1'b0; acc_type = 2'b10;
        @(negedge clk);
        @(negedge clk);
        check("R10 flag kept", {31'd0, err_flag}, 32'd1);
        check("R10 addr kept", {16'd0, err_addr}, 32'hA5A5);
        check("R10 attrs kept", {28'd0, err_master, err_super, err_type}, 32'b1101);
        acc_valid = 1'b0;
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R11 release", {31'd0, err_flag}, 32'd0);
        acc_valid = 1'b1; acc_addr = 16'h2222; acc_master = 1'b0;
        acc_super = 1'b0; acc_type = 2'b00;
        @(negedge clk);
        check("R9 second capture", {16'd0, err_addr}, 32'h2222);
        acc_addr = 16'h3C3C; acc_master = 1'b1; acc_super = 1'b0; acc_type = 2'b10;
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        acc_valid = 1'b0;
        check("R11 recapture flag", {31'd0, err_flag}, 32'd1);
        check("R11 recapture addr", {16'd0, err_addr}, 32'h3C3C);
        check("R11 recapture attrs", {28'd0, err_master, err_super, err_type}, 32'b1010);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule